// File: doc/BRIEF.md
# Clock calendar timekeeping counter

This block keeps wall-clock time and calendar date in BCD registers. A slow tick comes in on `tick_en`. The tick can be a 32.768 kHz oscillator pulse, which passes through an exact fractional divider to give 100 steps per second. It can also be a 50 Hz pulse, where each tick moves the hundredths field on by two. Each step advances hundredths of a second. Carries then ripple through seconds, minutes and hours, and on into a packed day-of-month/year register and a packed weekday/month register.

The hours register can run in 24-hour form or in 12-hour form with an AM/PM flag. The calendar follows a four-year cycle in which year count 0 is the leap year. A host write port loads any time or date register at any moment. A bus interface would drive this port. In a cycle that carries a write, the whole counter chain holds still.

Top module: `clk_cal_core`

## Requirements
- R1: After reset the registers read hundredths 00h, seconds 00h, minutes 00h, hours 00h (24-hour mode), year/day 01h and weekday/month 01h.
- R2: With `tb_sel`=0 the hundredths field advances once after 327 ticks and again after the next 328 ticks. 32768 ticks from reset give exactly one second, so the time reads seconds 01h and hundredths 00h.
- R3: With `tb_sel`=1 each tick adds 2 to the BCD hundredths field, and 98 rolls to 00 with a carry into seconds.
- R4: Hundredths, seconds and minutes count in BCD. Seconds and minutes roll from 59 to 00, and each rollover carries into the next field.
- R5: With hours bit 7 = 0 (24-hour mode), hours bits 5:0 count BCD 00 to 23. The step from 09 gives 10, and the step from 23 gives 00 and advances the date.
- R6: With hours bit 7 = 1 (12-hour mode), bits 5:0 count 12, 01, ..., 11 and bit 6 is the PM flag. The PM flag toggles on the step from 11 to 12. The date advances only on the step from 11 PM to 12 AM.
- R7: The year/day register keeps a 2-bit year count in bits 7:6 and a BCD day in bits 5:0. The day rolls to 01 after the last day of the month: day 30 for months 04, 06, 09 and 11, and day 31 for the other months apart from February.
- R8: February (month 02) ends on day 29 when the year count is 0 and on day 28 otherwise.
- R9: The weekday/month register keeps a 3-bit weekday in bits 7:5 and a BCD month 01 to 12 in bits 4:0. Month 12 rolls to 01 and increments the year count, which wraps modulo 4.
- R10: The weekday advances by one on every day change and wraps from 6 to 0.
- R11: A write with `wr_en`=1 loads `wr_data` into the addressed register: 1 hundredths, 2 seconds, 3 minutes, 4 hours, 5 year/day, 6 weekday/month. No field advances in that cycle, even if a step falls due.
- R12: Writes to addresses 0 and 7 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One pulse per time-base period |
| tb_sel | input | 1 | Time base: 0 = 32.768 kHz, 1 = 50 Hz |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 3 | Host register address |
| wr_data | input | 8 | Host write data |
| hund | output | 8 | BCD hundredths of a second |
| sec | output | 8 | BCD seconds |
| mins | output | 8 | BCD minutes |
| hrs | output | 8 | Mode, PM flag and BCD hour |
| yr_day | output | 8 | Year count and BCD day of month |
| wday_mon | output | 8 | Weekday and BCD month |

## Verification
Every register update, whether from a step or from a host write, appears at the same clock edge that samples the tick or the write. The step pulse is combinational from the divider state, so the full cascade from hundredths to the year count settles in that one edge. The bench drives ticks and writes at the falling edge and checks at the next falling edge. A burst of N ticks is N consecutive high cycles, checked at the falling edge after the Nth rising edge. The divider checks read the count one tick before and one tick after each boundary. This pins down exactly which tick moves the hundredths.

// File: rtl/clk_cal_pkg.sv
package clk_cal_pkg;
   localparam logic [2:0] ADR_HUND = 3'd1;
   localparam logic [2:0] ADR_SEC  = 3'd2;
   localparam logic [2:0] ADR_MIN  = 3'd3;
   localparam logic [2:0] ADR_HRS  = 3'd4;
   localparam logic [2:0] ADR_YD   = 3'd5;
   localparam logic [2:0] ADR_WM   = 3'd6;

   function automatic logic [7:0] bcd2bin(input logic [7:0] b);
      return 8'(b[7:4]) * 8'd10 + 8'(b[3:0]);
   endfunction

   function automatic logic [7:0] bin2bcd(input logic [7:0] v);
      return {4'(v / 8'd10), 4'(v % 8'd10)};
   endfunction

   // last day of a month, BCD
   function automatic logic [5:0] last_day(input logic [4:0] mon, input logic [1:0] yr);
      case (mon)
         5'h02:                      return (yr == 2'd0) ? 6'h29 : 6'h28;
         5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
         default:                    return 6'h31;
      endcase
   endfunction
endpackage

// File: rtl/cc_tick_prescaler.sv
module cc_tick_prescaler #(
   parameter int IN_HZ   = 32768,
   parameter int STEP_HZ = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_en,
   input  logic tb_sel,
   output logic step
);
   localparam int DIV_INT = IN_HZ / STEP_HZ;
   localparam int DIV_REM = IN_HZ % STEP_HZ;
   localparam int CNT_W   = $clog2(DIV_INT + 1);
   localparam int ACC_W   = $clog2(STEP_HZ + 1) + 1;

   logic [CNT_W-1:0] cnt_q;
   logic             wrap;

   assign step = tb_sel ? tick_en : (tick_en & wrap);

   generate
      if (DIV_REM != 0) begin : g_frac
         logic [ACC_W-1:0] acc_q;
         logic [ACC_W-1:0] acc_sum;
         logic             long_per;
         assign acc_sum  = acc_q + ACC_W'(DIV_REM);
         assign long_per = acc_sum >= ACC_W'(STEP_HZ);
         assign wrap     = long_per ? (cnt_q == CNT_W'(DIV_INT))
                                    : (cnt_q == CNT_W'(DIV_INT - 1));
         always_ff @(posedge clk) begin
            if (!rst_n || tb_sel) begin
               cnt_q <= '0;
               acc_q <= '0;
            end else if (tick_en) begin
               if (wrap) begin
                  cnt_q <= '0;
                  acc_q <= long_per ? acc_sum - ACC_W'(STEP_HZ) : acc_sum;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
         end
      end else begin : g_int
         assign wrap = cnt_q == CNT_W'(DIV_INT - 1);
         always_ff @(posedge clk) begin
            if (!rst_n || tb_sel)  cnt_q <= '0;
            else if (tick_en)      cnt_q <= wrap ? '0 : cnt_q + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/cc_time_chain.sv
module cc_time_chain
   import clk_cal_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       step,
   input  logic       dbl,
   input  logic       wr_en,
   input  logic [2:0] wr_addr,
   input  logic [7:0] wr_data,
   output logic [7:0] hund,
   output logic [7:0] sec,
   output logic [7:0] mins,
   output logic [7:0] hrs,
   output logic       day_carry
);
   logic [7:0] hund_n, sec_n, min_n, hrs_n;
   logic [7:0] hb, sb, mb, hrb, tmp;
   logic       c_h, c_s, c_m, c_d;

   always_comb begin
      hb     = bcd2bin(hund) + (dbl ? 8'd2 : 8'd1);
      c_h    = hb >= 8'd100;
      hund_n = bin2bcd(c_h ? hb - 8'd100 : hb);
      sb     = bcd2bin(sec);
      c_s    = c_h && (sb >= 8'd59);
      sec_n  = c_s ? 8'h00 : (c_h ? bin2bcd(sb + 8'd1) : sec);
      mb     = bcd2bin(mins);
      c_m    = c_s && (mb >= 8'd59);
      min_n  = c_m ? 8'h00 : (c_s ? bin2bcd(mb + 8'd1) : mins);
      hrb    = bcd2bin({2'b00, hrs[5:0]});
      tmp    = bin2bcd(hrb + 8'd1);
      hrs_n  = hrs;
      c_d    = 1'b0;
      if (c_m) begin
         if (!hrs[7]) begin
            if (hrb >= 8'd23) begin
               hrs_n = 8'h00;
               c_d   = 1'b1;
            end else begin
               hrs_n = {2'b00, tmp[5:0]};
            end
         end else if (hrb == 8'd11) begin
            hrs_n = {1'b1, ~hrs[6], 6'h12};
            c_d   = hrs[6];
         end else if (hrb >= 8'd12) begin
            hrs_n = {hrs[7:6], 6'h01};
         end else begin
            hrs_n = {hrs[7:6], tmp[5:0]};
         end
      end
   end

   assign day_carry = step & ~wr_en & c_d;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hund <= 8'h00;
         sec  <= 8'h00;
         mins <= 8'h00;
         hrs  <= 8'h00;
      end else if (wr_en) begin
         case (wr_addr)
            ADR_HUND: hund <= wr_data;
            ADR_SEC:  sec  <= wr_data;
            ADR_MIN:  mins <= wr_data;
            ADR_HRS:  hrs  <= wr_data;
            default:  ;
         endcase
      end else if (step) begin
         hund <= hund_n;
         sec  <= sec_n;
         mins <= min_n;
         hrs  <= hrs_n;
      end
   end
endmodule

// File: rtl/cc_date_chain.sv
module cc_date_chain
   import clk_cal_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       day_carry,
   input  logic       wr_en,
   input  logic [2:0] wr_addr,
   input  logic [7:0] wr_data,
   output logic [7:0] yr_day,
   output logic [7:0] wday_mon
);
   logic [5:0] dim;
   logic [7:0] day_b, mon_b, day_inc, mon_inc;
   logic [7:0] yd_n, wm_n;
   logic [2:0] wd_n;

   always_comb begin
      dim     = last_day(wday_mon[4:0], yr_day[7:6]);
      day_b   = bcd2bin({2'b00, yr_day[5:0]});
      mon_b   = bcd2bin({3'b000, wday_mon[4:0]});
      day_inc = bin2bcd(day_b + 8'd1);
      mon_inc = bin2bcd(mon_b + 8'd1);
      wd_n    = (wday_mon[7:5] >= 3'd6) ? 3'd0 : wday_mon[7:5] + 3'd1;
      if (day_b >= bcd2bin({2'b00, dim})) begin
         if (mon_b >= 8'd12) begin
            yd_n = {yr_day[7:6] + 2'd1, 6'h01};
            wm_n = {wd_n, 5'h01};
         end else begin
            yd_n = {yr_day[7:6], 6'h01};
            wm_n = {wd_n, mon_inc[4:0]};
         end
      end else begin
         yd_n = {yr_day[7:6], day_inc[5:0]};
         wm_n = {wd_n, wday_mon[4:0]};
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         yr_day   <= 8'h01;
         wday_mon <= 8'h01;
      end else if (wr_en) begin
         if (wr_addr == ADR_YD) yr_day   <= wr_data;
         if (wr_addr == ADR_WM) wday_mon <= wr_data;
      end else if (day_carry) begin
         yr_day   <= yd_n;
         wday_mon <= wm_n;
      end
   end
endmodule

// File: rtl/clk_cal_core.sv
module clk_cal_core #(
   parameter int IN_HZ   = 32768,
   parameter int STEP_HZ = 100
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_en,
   input  logic       tb_sel,
   input  logic       wr_en,
   input  logic [2:0] wr_addr,
   input  logic [7:0] wr_data,
   output logic [7:0] hund,
   output logic [7:0] sec,
   output logic [7:0] mins,
   output logic [7:0] hrs,
   output logic [7:0] yr_day,
   output logic [7:0] wday_mon
);
   generate
      if (IN_HZ < 2 * STEP_HZ) begin : g_bad_ratio
         $error("IN_HZ must be at least twice STEP_HZ");
      end
      if (STEP_HZ != 100) begin : g_bad_step
         $error("hundredths field requires STEP_HZ of 100");
      end
   endgenerate

   logic step, day_carry;

   cc_tick_prescaler #(.IN_HZ(IN_HZ), .STEP_HZ(STEP_HZ)) u_pre (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .tb_sel(tb_sel), .step(step)
   );

   cc_time_chain u_time (
      .clk(clk), .rst_n(rst_n), .step(step), .dbl(tb_sel),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .hund(hund), .sec(sec), .mins(mins), .hrs(hrs), .day_carry(day_carry)
   );

   cc_date_chain u_date (
      .clk(clk), .rst_n(rst_n), .day_carry(day_carry),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .yr_day(yr_day), .wday_mon(wday_mon)
   );
endmodule

// File: rtl/clk_cal_core_chk.sv
module clk_cal_core_chk
   import clk_cal_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       tick_en,
   input logic       tb_sel,
   input logic       wr_en,
   input logic [2:0] wr_addr,
   input logic [7:0] wr_data,
   input logic [7:0] hund,
   input logic [7:0] sec,
   input logic [7:0] mins,
   input logic [7:0] hrs,
   input logic [7:0] yr_day,
   input logic [7:0] wday_mon
);
   // R11
   sec_write_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADR_SEC) |=> (sec == $past(wr_data)));

   // R12
   ignored_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_addr == 3'd0 || wr_addr == 3'd7)) |=>
      ($stable(hund) && $stable(sec) && $stable(mins) && $stable(hrs) &&
       $stable(yr_day) && $stable(wday_mon)));

   // R4
   minute_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(wr_en) && mins != $past(mins)) |-> (sec == 8'h00));

   // R10
   weekday_follows_day_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(wr_en) && yr_day[5:0] != $past(yr_day[5:0])) |->
      (wday_mon[7:5] != $past(wday_mon[7:5])));

   // R6
   hour_mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_en) |-> (hrs[7] == $past(hrs[7])));

   logic unused_ok;
   assign unused_ok = ^{tick_en, tb_sel};
endmodule

bind clk_cal_core clk_cal_core_chk u_chk (.*);

// File: tb/clk_cal_core_bench.sv
`timescale 1ns/1ps
module clk_cal_core_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b0;
   logic       tb_sel = 1'b1;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = 3'd0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] hund, sec, mins, hrs, yr_day, wday_mon;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   clk_cal_core u_clk_cal_core (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .tb_sel(tb_sel),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .hund(hund), .sec(sec), .mins(mins), .hrs(hrs),
      .yr_day(yr_day), .wday_mon(wday_mon)
   );

   typedef struct packed {
      logic [7:0] h, s, m, hr, yd, wm;
      logic [7:0] eh, es, em, ehr, eyd, ewm;
   } vec_t;

   // preload values, then one 50 Hz tick, then expected values
   localparam vec_t VECS [10] = '{
      '{8'h98,8'h59,8'h59,8'h23,8'h31,8'hD2, 8'h00,8'h00,8'h00,8'h00,8'h41,8'h01},
      '{8'h98,8'h59,8'h59,8'h23,8'h28,8'h42, 8'h00,8'h00,8'h00,8'h00,8'h29,8'h62},
      '{8'h98,8'h59,8'h59,8'h23,8'h68,8'hC2, 8'h00,8'h00,8'h00,8'h00,8'h41,8'h03},
      '{8'h98,8'h59,8'h59,8'h23,8'h29,8'h22, 8'h00,8'h00,8'h00,8'h00,8'h01,8'h43},
      '{8'h98,8'h59,8'h59,8'h23,8'hB0,8'h84, 8'h00,8'h00,8'h00,8'h00,8'h81,8'hA5},
      '{8'h98,8'h59,8'h59,8'h91,8'h15,8'h27, 8'h00,8'h00,8'h00,8'hD2,8'h15,8'h27},
      '{8'h98,8'h59,8'h59,8'hD1,8'h15,8'h27, 8'h00,8'h00,8'h00,8'h92,8'h16,8'h47},
      '{8'h98,8'h59,8'h59,8'h92,8'h15,8'h27, 8'h00,8'h00,8'h00,8'h81,8'h15,8'h27},
      '{8'h99,8'h59,8'h09,8'h10,8'h15,8'h27, 8'h01,8'h00,8'h10,8'h10,8'h15,8'h27},
      '{8'h98,8'h59,8'h59,8'h09,8'h15,8'h27, 8'h00,8'h00,8'h00,8'h10,8'h15,8'h27}
   };

   function automatic string vec_tag(input int i);
      case (i)
         0:       return "R9 R10 new year";
         1:       return "R8 leap February";
         2:       return "R8 common February";
         3:       return "R7 leap February end";
         4:       return "R7 thirty-day month";
         5:       return "R6 AM to PM";
         6:       return "R6 PM to AM";
         7:       return "R6 twelve to one";
         8:       return "R4 cascade";
         default: return "R5 24-hour BCD";
      endcase
   endfunction

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic run_ticks(input int n);
      @(negedge clk);
      tick_en = 1'b1;
      repeat (n) @(negedge clk);
      tick_en = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      do_reset();
      @(negedge clk);
      // R1
      check("R1 hund", hund, 8'h00);
      check("R1 sec", sec, 8'h00);
      check("R1 mins", mins, 8'h00);
      check("R1 hrs", hrs, 8'h00);
      check("R1 yr_day", yr_day, 8'h01);
      check("R1 wday_mon", wday_mon, 8'h01);

      tb_sel = 1'b1;
      for (int i = 0; i < 10; i++) begin
         wr(3'd1, VECS[i].h);
         wr(3'd2, VECS[i].s);
         wr(3'd3, VECS[i].m);
         wr(3'd4, VECS[i].hr);
         wr(3'd5, VECS[i].yd);
         wr(3'd6, VECS[i].wm);
         run_ticks(1);
         check(vec_tag(i), hund, VECS[i].eh);
         check(vec_tag(i), sec, VECS[i].es);
         check(vec_tag(i), mins, VECS[i].em);
         check(vec_tag(i), hrs, VECS[i].ehr);
         check(vec_tag(i), yr_day, VECS[i].eyd);
         check(vec_tag(i), wday_mon, VECS[i].ewm);
      end

      // R3 plain double step
      wr(3'd1, 8'h40);
      wr(3'd2, 8'h05);
      run_ticks(3);
      check("R3 hund +2 per tick", hund, 8'h46);
      check("R3 sec untouched", sec, 8'h05);

      // R11 write wins over a due step
      wr(3'd1, 8'h10);
      @(negedge clk);
      tick_en = 1'b1; wr_en = 1'b1; wr_addr = 3'd2; wr_data = 8'h30;
      @(negedge clk);
      tick_en = 1'b0; wr_en = 1'b0;
      check("R11 hund held", hund, 8'h10);
      check("R11 sec loaded", sec, 8'h30);

      // R12 ignored addresses
      wr(3'd7, 8'h55);
      wr(3'd0, 8'h77);
      @(negedge clk);
      check("R12 hund", hund, 8'h10);
      check("R12 sec", sec, 8'h30);
      check("R12 mins", mins, 8'h00);
      check("R12 wday_mon", wday_mon, 8'h27);

      // R2 fractional divider from reset
      tb_sel = 1'b0;
      do_reset();
      run_ticks(326);
      check("R2 before first step", hund, 8'h00);
      run_ticks(1);
      check("R2 first step at 327", hund, 8'h01);
      run_ticks(327);
      check("R2 before second step", hund, 8'h01);
      run_ticks(1);
      check("R2 second step at 328", hund, 8'h02);
      run_ticks(32768 - 655 - 1);
      check("R2 one tick short of a second", sec, 8'h00);
      run_ticks(1);
      check("R2 one second sec", sec, 8'h01);
      check("R2 one second hund", hund, 8'h00);

      finish_run();
   end
endmodule